// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Registered Flags

This block is the arithmetic and logic core of a small accumulator machine. Each cycle it takes the accumulator value, a second byte and a four-bit operation code. The second byte is already fetched by the caller and may come from a register, memory or an immediate field. The block always presents the byte result on its output. It sets the carry, zero, sign and parity flags only on a clock edge where the operation is marked valid. The caller writes the result back to the accumulator or to the chosen register.

The stored carry feeds the add-with-carry and subtract-with-borrow operations. Two operations are separate single-purpose commands: one inverts the accumulator, the other flips the carry. A condition evaluator reads the stored flags and answers a four-bit condition select. This answer drives conditional jump, call and return decisions. Decimal adjust and operand fetch are outside this block.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add) gives `result` = (a_in + b_in) mod 256. On a valid edge, carry is set to the ninth bit of the sum.
- R2: Op code 1 (add with carry) gives `result` = (a_in + b_in + cy) mod 256, where cy is the stored carry. On a valid edge, carry takes the ninth bit of the sum.
- R3: Op code 2 (subtract) gives a_in − b_in, and op code 3 (subtract with borrow) gives a_in − b_in − cy, both mod 256. On a valid edge, carry is set exactly when b_in plus the borrow-in exceeds a_in.
- R4: Op codes 4, 5 and 6 give the bitwise AND, OR and XOR of a_in and b_in. On a valid edge they clear carry.
- R5: Op code 7 gives a_in + 1 and op code 8 gives a_in − 1, both wrapping mod 256. Carry is left unchanged.
- R6: Op code 9 gives `result` = ~a_in, so FFh becomes 00h. No flag changes.
- R7: Op code 10 inverts only the carry flag, and `result` equals a_in.
- R8: For op codes 0 to 8, a valid edge sets zf to (result == 0), sf to result bit 7, and pf to 1 when result has an even number of ones.
- R9: Flags keep their value on any edge where op_valid is low. Op codes 11 to 15 give `result` = a_in and change no flag.
- R10: `cond_true` is evaluated from the stored flags. With cond_sel[3] = 0, codes 0..7 select nonzero (!zf), zero (zf), no carry (!cy), carry (cy), odd parity (!pf), even parity (pf), plus (!sf) and minus (sf). With cond_sel[3] = 1 the answer is always true.
- R11: With rst_n low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Commit flags for this operation at the edge |
| op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator or register being operated on |
| b_in | input | 8 | Second operand byte |
| result | output | 8 | Combinational result byte |
| cy | output | 1 | Stored carry / borrow flag |
| zf | output | 1 | Stored zero flag |
| sf | output | 1 | Stored sign flag |
| pf | output | 1 | Stored parity flag (1 = even ones) |
| cond_sel | input | 4 | Branch condition select |
| cond_true | output | 1 | Selected condition holds |

## Verification
A wrong stored carry has two visible effects. It changes `result` for the very next add-with-carry or subtract-with-borrow, in the same cycle those inputs are applied. It also flips `cond_true` for the carry and no-carry selects right after the edge that wrote it. A bad zero, sign or parity flag appears on `cy`, `zf`, `sf`, `pf` and on the matching condition select one edge after the faulty operation. The bench therefore checks every flag and all sixteen condition selects after every committed operation. A fault is caught at most one operation after it occurs.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] result,
  output logic         cy,
  output logic         zf,
  output logic         sf,
  output logic         pf,
  input  logic [3:0]   cond_sel,
  output logic         cond_true
);

  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
                         OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_INC = 4'd7,
                         OP_DEC = 4'd8, OP_CMA = 4'd9, OP_CMC = 4'd10;

  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W:0] ax, bx, cx, wide;
  logic       c_nxt, set_zsp;

  assign ax = {1'b0, a_in};
  assign bx = {1'b0, b_in};
  assign cx = {{W{1'b0}}, cy};

  always_comb begin
    wide    = ax;
    c_nxt   = cy;
    set_zsp = 1'b1;
    case (op)
      OP_ADD: begin wide = ax + bx;      c_nxt = wide[W]; end
      OP_ADC: begin wide = ax + bx + cx; c_nxt = wide[W]; end
      OP_SUB: begin wide = ax - bx;      c_nxt = wide[W]; end
      OP_SBB: begin wide = ax - bx - cx; c_nxt = wide[W]; end
      OP_AND: begin wide = ax & bx;      c_nxt = 1'b0;    end
      OP_OR:  begin wide = ax | bx;      c_nxt = 1'b0;    end
      OP_XOR: begin wide = ax ^ bx;      c_nxt = 1'b0;    end
      OP_INC: wide = ax + ONE;
      OP_DEC: wide = ax - ONE;
      OP_CMA: begin wide = {1'b0, ~a_in}; set_zsp = 1'b0; end
      OP_CMC: begin c_nxt = ~cy;          set_zsp = 1'b0; end
      default: set_zsp = 1'b0;
    endcase
  end

  assign result = wide[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy <= 1'b0;
      zf <= 1'b0;
      sf <= 1'b0;
      pf <= 1'b0;
    end else if (op_valid) begin
      cy <= c_nxt;
      if (set_zsp) begin
        zf <= (result == '0);
        sf <= result[W-1];
        pf <= ~^result;
      end
    end
  end

  logic base;
  always_comb begin
    case (cond_sel[2:1])
      2'd0:    base = zf;
      2'd1:    base = cy;
      2'd2:    base = pf;
      default: base = sf;
    endcase
  end
  assign cond_true = cond_sel[3] | (cond_sel[0] ? base : ~base);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({cy, zf, sf, pf}));
  a_r5_incdec_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_INC || op == OP_DEC)) |=> cy == $past(cy));
  a_r4_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !cy);
  a_r7_cmc_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CMC) |=> (cy != $past(cy)) && $stable({zf, sf, pf}));
  a_r6_cma_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CMA) |=> $stable({cy, zf, sf, pf}));
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op <= OP_DEC) |=> zf == ($past(result) == '0));
  a_r10_always: assert property (@(posedge clk) disable iff (!rst_n)
    cond_sel[3] |-> cond_true);

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [3:0] op = 0, cond_sel = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic [7:0] result;
  logic cy, zf, sf, pf, cond_true;
  int checks = 0, fails = 0;
  bit done = 0;
  bit m_cy = 0, m_z = 0, m_s = 0, m_p = 0;

  always #10 clk = ~clk;

  acc_alu u_dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .a_in(a_in),
    .b_in(b_in), .result(result), .cy(cy), .zf(zf), .sf(sf), .pf(pf),
    .cond_sel(cond_sel), .cond_true(cond_true));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " cy"}, cy, m_cy);
    chk({req, " zf"}, zf, m_z);
    chk({req, " sf"}, sf, m_s);
    chk({req, " pf"}, pf, m_p);
  endtask

  task automatic chk_conds();
    for (int i = 0; i < 16; i++) begin
      bit e;
      cond_sel = 4'(i);
      #1;
      case (i)
        0: e = !m_z;  1: e = m_z;  2: e = !m_cy; 3: e = m_cy;
        4: e = !m_p;  5: e = m_p;  6: e = !m_s;  7: e = m_s;
        default: e = 1;
      endcase
      chk("R10 cond", cond_true, e);
    end
  endtask

  task automatic apply(input string req, input logic [3:0] o, input logic [7:0] a,
                       input logic [7:0] b, input bit valid);
    logic [8:0] w;
    bit nc, zsp;
    nc = m_cy; zsp = 1; w = {1'b0, a};
    case (o)
      0: begin w = a + b;                 nc = w[8]; end
      1: begin w = a + b + m_cy;          nc = w[8]; end
      2: begin w = {1'b0,a} - {1'b0,b};   nc = (b > a); end
      3: begin w = {1'b0,a} - {1'b0,b} - 9'(m_cy); nc = (9'(b) + 9'(m_cy) > 9'(a)); end
      4: begin w = {1'b0, a & b}; nc = 0; end
      5: begin w = {1'b0, a | b}; nc = 0; end
      6: begin w = {1'b0, a ^ b}; nc = 0; end
      7: w = {1'b0, a + 8'd1};
      8: w = {1'b0, a - 8'd1};
      9: begin w = {1'b0, ~a}; zsp = 0; end
      10: begin nc = !m_cy; zsp = 0; end
      default: zsp = 0;
    endcase
    @(negedge clk);
    op = o; a_in = a; b_in = b; op_valid = valid;
    #2 chk({req, " result"}, result, w[7:0]);
    @(posedge clk); #1 op_valid = 0;
    if (valid) begin
      m_cy = nc;
      if (zsp) begin m_z = (w[7:0] == 0); m_s = w[7]; m_p = ~^w[7:0]; end
    end
    @(negedge clk);
    chk_flags(req);
    chk_conds();
  endtask

  task automatic t_reset();  chk_flags("R11 reset"); chk_conds(); endtask
  task automatic t_add();
    apply("R1 add", 0, 8'h12, 8'h34, 1);
    apply("R1 add carry", 0, 8'hF0, 8'h20, 1);
    apply("R1 add zero", 0, 8'h80, 8'h80, 1);
  endtask
  task automatic t_adc();
    apply("R2 adc cin1", 1, 8'h10, 8'h01, 1);
    apply("R2 adc cin0", 1, 8'hFF, 8'h01, 1);
    apply("R2 adc chain", 1, 8'h7F, 8'h00, 1);
  endtask
  task automatic t_sub();
    apply("R3 sub", 2, 8'h50, 8'h20, 1);
    apply("R3 sub borrow", 2, 8'h05, 8'h06, 1);
    apply("R3 sbb b1", 3, 8'h10, 8'h0F, 1);
    apply("R3 sbb eq", 3, 8'h20, 8'h20, 1);
    apply("R3 sub FF", 2, 8'h00, 8'hFF, 1);
    apply("R3 sbb edge", 3, 8'h00, 8'hFF, 1);
  endtask
  task automatic t_logic();
    apply("R0 setc", 0, 8'hFF, 8'h01, 1);
    apply("R4 and", 4, 8'hF0, 8'h3C, 1);
    apply("R0 setc", 0, 8'hFF, 8'h01, 1);
    apply("R4 or", 5, 8'h81, 8'h02, 1);
    apply("R4 xor self", 6, 8'hA5, 8'hA5, 1);
  endtask
  task automatic t_incdec();
    apply("R0 setc", 0, 8'hFF, 8'h02, 1);
    apply("R5 inc wrap", 7, 8'hFF, 8'h00, 1);
    apply("R5 dec wrap", 8, 8'h00, 8'h00, 1);
    apply("R5 inc", 7, 8'h7F, 8'h00, 1);
  endtask
  task automatic t_cma_cmc();
    apply("R6 cma FF", 9, 8'hFF, 8'h00, 1);
    apply("R6 cma", 9, 8'h0F, 8'h00, 1);
    apply("R7 cmc", 10, 8'h33, 8'h00, 1);
    apply("R7 cmc back", 10, 8'h33, 8'h00, 1);
  endtask
  task automatic t_idle();
    apply("R9 idle add", 0, 8'hFF, 8'hFF, 0);
    apply("R9 idle sub", 2, 8'h00, 8'h01, 0);
    for (int c = 11; c < 16; c++) apply("R9 unused code", 4'(c), 8'h5A, 8'h00, 1);
    apply("R8 parity odd", 5, 8'h01, 8'h00, 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #35;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_add(); t_adc(); t_sub(); t_logic(); t_incdec(); t_cma_cmc(); t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule